// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Sequencer

This block is the digital controller of a successive-approximation converter that talks to a host over a three-wire synchronous serial port. While the select line is low, the host clocks a four-bit multiplexer address into the block. The first bit chooses the input pairing and the next three bits choose the channel. Right after the fourth address bit, the block runs an eleven-step binary search on a single-bit comparator input. The search resolves the sign first and then ten magnitude bits. A status pin reports that the search is in progress. When the search ends, the block returns the sign-magnitude result over its serial output, least significant bit first, with the sign as the last bit.

All port inputs are sampled by a fast system clock. The serial clock, the select line and the serial data pass through a synchronizer, and the block acts on the edges it detects on the synchronized serial clock. Each output pin that the host sees comes with its own enable, so that the pin driver can be put into high impedance. After each cycle the host must keep the select line high for a minimum number of system clocks before the block accepts a new address. A power-down input forces the sequencer back to idle and silences both pins.

Top module: `sar_serial_sequencer`

## Requirements
- R1: With the select line low, each rising serial clock edge shifts one address bit in. After the fourth bit, the outputs show the word: the first bit received is the differential flag (mux_diff, 1 = differential), and the next three bits are the channel number, most significant bit first (mux_chan).
- R2: The search starts at the fourth address edge. While the select line is low, the busy pin is high for exactly the next eleven rising serial clock edges and low at every other time.
- R3: At the start of the search, trial_code holds only bit 10 (the sign trial). Each rising edge then settles one bit, in the order bit 10 (sign), bit 9, and so on down to bit 0. A bit is kept as 1 when cmp_hi is high and cleared otherwise, and the bit below it is set as the next trial. At the end, trial_code holds {sign, magnitude}.
- R4: Starting with the falling serial clock edge that follows the last search edge, each falling edge places the next result bit on ser_out: bit 0 first, then bits 1 to 9, and the sign bit (bit 10) eleventh.
- R5: ser_out_en is high only while the select line is low and the search has finished. It drops when the select line goes high, and it is never high together with busy.
- R6: busy_en follows the inverted select line while the block is powered up. When busy_en is low, busy is low as well.
- R7: While pwr_dn is high, busy, busy_en and ser_out_en stay low, trial_code is cleared, and rising serial clock edges do not change mux_diff or mux_chan.
- R8: Once a search has started, the select line must stay high for CS_HOLD consecutive system clocks before a new address is accepted. If it goes low again sooner, the serial clock is ignored and busy and ser_out_en stay low.
- R9: After reset, busy, busy_en, ser_out_en, ser_out, mux_diff, mux_chan and trial_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Active-low select |
| ser_in | input | 1 | Serial address bit |
| cmp_hi | input | 1 | Comparator decision for the current trial |
| pwr_dn | input | 1 | High forces power-down |
| ser_out | output | 1 | Serial result bit |
| ser_out_en | output | 1 | Drive enable for ser_out |
| busy | output | 1 | Search in progress |
| busy_en | output | 1 | Drive enable for busy |
| mux_diff | output | 1 | Latched pairing: 1 = differential |
| mux_chan | output | 3 | Latched channel number |
| trial_code | output | 11 | Trial word for the reference ladder: sign at bit 10, magnitude below |

## Verification
On every cycle the assertions check the pin relations: busy is never high without its enable, the result enable and busy never overlap, power-down silences the pins one clock later, the trial word holds only the sign trial when busy rises, and the latched address is stable while busy is high. Only the bench scenarios can show the serial ordering: which address bit lands in which field, that the binary search reproduces a comparator model's value over a sweep of channels and magnitudes (including zero and full scale of either sign), the exact bit order on ser_out, and that a select pulse shorter than the hold time leaves the block deaf to the next address.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_SEND,
    ST_REC
  } seq_state_t;
endpackage

// File: rtl/sar_seq_sync.sv
// Multi-stage synchronizer for slow host-side inputs.
module sar_seq_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sar_seq_search.sv
// Binary-search register: one bit settled per step, top bit first.
module sar_seq_search #(
  parameter int TOP = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         start,
  input  logic         step_en,
  input  logic         cmp_hi,
  output logic [TOP:0] code,
  output logic         last
);
  localparam int SW = $clog2(TOP + 1);

  logic [SW-1:0] step;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      code <= '0;
      step <= '0;
    end else if (start) begin
      code <= (TOP + 1)'(1) << TOP;
      step <= SW'(TOP);
    end else if (step_en) begin
      code[step] <= cmp_hi;
      if (step != '0) begin
        code[step - SW'(1)] <= 1'b1;
        step <= step - SW'(1);
      end
    end
  end

  assign last = (step == '0);
endmodule

// File: rtl/sar_seq_shift.sv
// Result shifter: low-order bit leaves first.
module sar_seq_shift #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         shift_en,
  output logic         bit_out
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      cnt     <= '0;
      bit_out <= 1'b0;
    end else if (load) begin
      sh      <= data;
      cnt     <= '0;
      bit_out <= 1'b0;
    end else if (shift_en && cnt != CW'(W)) begin
      bit_out <= sh[0];
      sh      <= sh >> 1;
      cnt     <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sar_serial_sequencer.sv
module sar_serial_sequencer
  import sar_seq_pkg::*;
#(
  parameter int MAG_W       = 10,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CS_HOLD     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              sel_n,
  input  logic              ser_in,
  input  logic              cmp_hi,
  input  logic              pwr_dn,
  output logic              ser_out,
  output logic              ser_out_en,
  output logic              busy,
  output logic              busy_en,
  output logic              mux_diff,
  output logic [ADDR_W-2:0] mux_chan,
  output logic [MAG_W:0]    trial_code
);
  localparam int RES_W = MAG_W + 1;
  localparam int ACW   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam int HCW   = $clog2(CS_HOLD + 1);

  seq_state_t state;

  logic [2:0] sync_q;
  logic       s_clk, s_sel_n, s_din, s_clk_d;
  logic       clk_rise, clk_fall;

  logic [ADDR_W-2:0] addr_sr;
  logic [ACW-1:0]    bit_cnt;
  logic [HCW-1:0]    hold_cnt;

  logic start, step_en, last, done, shift_en;

  sar_seq_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) i_sync (
    .clk(clk), .rst(rst),
    .d({ser_clk, sel_n, ser_in}),
    .q(sync_q)
  );

  assign s_clk   = sync_q[2];
  assign s_sel_n = sync_q[1];
  assign s_din   = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) s_clk_d <= 1'b0;
    else     s_clk_d <= s_clk;
  end

  assign clk_rise = s_clk & ~s_clk_d;
  assign clk_fall = ~s_clk & s_clk_d;

  assign start    = !pwr_dn && state == ST_IDLE && !s_sel_n && clk_rise
                    && bit_cnt == ACW'(ADDR_W - 1);
  assign step_en  = !pwr_dn && state == ST_CONV && !s_sel_n && clk_rise;
  assign done     = step_en && last;
  assign shift_en = !pwr_dn && state == ST_SEND && !s_sel_n && clk_fall;

  sar_seq_search #(.TOP(MAG_W)) i_search (
    .clk(clk), .rst(rst), .clear(pwr_dn),
    .start(start), .step_en(step_en), .cmp_hi(cmp_hi),
    .code(trial_code), .last(last)
  );

  sar_seq_shift #(.W(RES_W)) i_shift (
    .clk(clk), .rst(rst),
    .load(done), .data({trial_code[MAG_W:1], cmp_hi}),
    .shift_en(shift_en), .bit_out(ser_out)
  );

  // Sequencer state
  always_ff @(posedge clk) begin
    if (rst || pwr_dn) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      hold_cnt <= '0;
      addr_sr  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (s_sel_n) begin
            bit_cnt <= '0;
          end else if (clk_rise) begin
            addr_sr <= {addr_sr[ADDR_W-3:0], s_din};
            if (bit_cnt == ACW'(ADDR_W - 1)) begin
              bit_cnt <= '0;
              state   <= ST_CONV;
            end else begin
              bit_cnt <= bit_cnt + ACW'(1);
            end
          end
        end
        ST_CONV: begin
          if (s_sel_n) begin
            state    <= ST_REC;
            hold_cnt <= '0;
          end else if (done) begin
            state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (s_sel_n) begin
            state    <= ST_REC;
            hold_cnt <= '0;
          end
        end
        default: begin
          if (!s_sel_n) begin
            hold_cnt <= '0;
          end else if (hold_cnt == HCW'(CS_HOLD - 1)) begin
            state <= ST_IDLE;
          end else begin
            hold_cnt <= hold_cnt + HCW'(1);
          end
        end
      endcase
    end
  end

  // Latched multiplexer selection
  always_ff @(posedge clk) begin
    if (rst) begin
      mux_diff <= 1'b0;
      mux_chan <= '0;
    end else if (start) begin
      {mux_diff, mux_chan} <= {addr_sr, s_din};
    end
  end

  // Registered pin status and enables
  always_ff @(posedge clk) begin
    if (rst || pwr_dn) begin
      busy       <= 1'b0;
      busy_en    <= 1'b0;
      ser_out_en <= 1'b0;
    end else begin
      busy_en    <= !s_sel_n;
      busy       <= !s_sel_n && state == ST_CONV;
      ser_out_en <= !s_sel_n && state == ST_SEND;
    end
  end
endmodule

// File: rtl/sar_serial_sequencer_chk.sv
module sar_serial_sequencer_chk #(
  parameter int MAG_W  = 10,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_dn,
  input logic              busy,
  input logic              busy_en,
  input logic              ser_out_en,
  input logic              mux_diff,
  input logic [ADDR_W-2:0] mux_chan,
  input logic [MAG_W:0]    trial_code
);
  a_r6_busy_needs_en: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_en);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(busy && ser_out_en));

  a_r5_send_not_into_conv: assert property (@(posedge clk) disable iff (rst)
    ser_out_en |=> !busy);

  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (!busy && !busy_en && !ser_out_en && trial_code == '0));

  a_r3_sign_trial_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> trial_code == ((MAG_W + 1)'(1) << MAG_W));

  a_r1_mux_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable({mux_diff, mux_chan}));
endmodule

bind sar_serial_sequencer sar_serial_sequencer_chk #(
  .MAG_W(MAG_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .busy(busy), .busy_en(busy_en),
  .ser_out_en(ser_out_en), .mux_diff(mux_diff), .mux_chan(mux_chan),
  .trial_code(trial_code)
);

// File: tb/test_sar_serial_sequencer.sv
module test_sar_serial_sequencer;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        sel_n = 1'b1;
  logic        ser_in = 1'b0;
  logic        pwr_dn = 1'b0;
  logic        cmp_hi;
  logic        ser_out, ser_out_en, busy, busy_en, mux_diff;
  logic [2:0]  mux_chan;
  logic [10:0] trial_code;

  logic        m_neg = 1'b0;
  logic [9:0]  m_mag = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // Comparator model: sign trial when low bits are zero, else magnitude compare
  assign cmp_hi = (trial_code[9:0] == 10'd0) ? m_neg : (m_mag >= trial_code[9:0]);

  sar_serial_sequencer i_sar_serial_sequencer (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
    .cmp_hi(cmp_hi), .pwr_dn(pwr_dn), .ser_out(ser_out), .ser_out_en(ser_out_en),
    .busy(busy), .busy_en(busy_en), .mux_diff(mux_diff), .mux_chan(mux_chan),
    .trial_code(trial_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk);
    ser_clk = 1'b1;
    idle(H);
    ser_clk = 1'b0;
    idle(H);
  endtask

  task automatic send_addr(input logic [3:0] a);
    for (int i = 3; i >= 0; i--) begin
      ser_in = a[i];
      pulse();
    end
  endtask

  task automatic run(input logic [3:0] a, input logic neg, input logic [9:0] mag);
    logic [10:0] e;
    e = {neg, mag};
    m_neg = neg;
    m_mag = mag;
    @(negedge clk);
    sel_n = 1'b0;
    idle(6);
    chk(busy_en == 1'b1, "R6 busy_en on select", int'(busy_en), 1);
    send_addr(a);
    chk({mux_diff, mux_chan} == a, "R1 address", int'({mux_diff, mux_chan}), int'(a));
    chk(busy == 1'b1, "R2 busy at start", int'(busy), 1);
    chk(trial_code == 11'h400, "R3 sign trial", int'(trial_code), 1024);
    for (int k = 0; k < 11; k++) begin
      pulse();
      if (k == 9) chk(busy == 1'b1, "R2 busy before last step", int'(busy), 1);
    end
    chk(busy == 1'b0, "R2 busy after eleven steps", int'(busy), 0);
    chk(ser_out_en == 1'b1, "R5 output enabled", int'(ser_out_en), 1);
    chk(trial_code == e, "R3 result", int'(trial_code), int'(e));
    chk(ser_out == e[0], "R4 bit 0", int'(ser_out), int'(e[0]));
    for (int b = 1; b < 11; b++) begin
      pulse();
      chk(ser_out == e[b], "R4 serial bit", int'(ser_out), int'(e[b]));
    end
    sel_n = 1'b1;
    idle(6);
    chk(ser_out_en == 1'b0, "R5 output off with select high", int'(ser_out_en), 0);
    chk(busy_en == 1'b0, "R6 busy_en off with select high", int'(busy_en), 0);
    idle(20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(3);
    // R9 reset state
    chk(busy == 1'b0 && busy_en == 1'b0 && ser_out_en == 1'b0, "R9 pins",
        int'({busy, busy_en, ser_out_en}), 0);
    chk(ser_out == 1'b0, "R9 ser_out", int'(ser_out), 0);
    chk({mux_diff, mux_chan} == 4'd0 && trial_code == 11'd0, "R9 mux and trial",
        int'({mux_diff, mux_chan, trial_code}), 0);

    // Sweep all addresses with computed values
    for (int a = 0; a < 16; a++) begin
      run(4'(a), logic'(a[0] ^ a[3]), 10'((a * 389 + 57) % 1024));
    end
    // Corner values
    run(4'd5, 1'b0, 10'd0);
    run(4'd10, 1'b1, 10'd1023);
    run(4'd3, 1'b1, 10'd0);
    run(4'd12, 1'b0, 10'd1023);
    run(4'd9, 1'b0, 10'd512);

    // R8: short select-high pulse after a cycle leaves the block deaf
    m_neg = 1'b0;
    m_mag = 10'd100;
    @(negedge clk);
    sel_n = 1'b0;
    idle(6);
    send_addr(4'd6);
    for (int k = 0; k < 11; k++) pulse();
    @(negedge clk);
    sel_n = 1'b1;
    idle(3);
    sel_n = 1'b0;
    idle(6);
    send_addr(4'd11);
    chk({mux_diff, mux_chan} == 4'd6, "R8 address ignored", int'({mux_diff, mux_chan}), 6);
    chk(busy == 1'b0, "R8 no search", int'(busy), 0);
    chk(ser_out_en == 1'b0, "R8 output off", int'(ser_out_en), 0);
    sel_n = 1'b1;
    idle(20);
    run(4'd11, 1'b1, 10'd300);

    // R7: power-down mid-search, serial clock ignored
    m_neg = 1'b0;
    m_mag = 10'd700;
    @(negedge clk);
    sel_n = 1'b0;
    idle(6);
    send_addr(4'd2);
    pulse();
    pulse();
    @(negedge clk);
    pwr_dn = 1'b1;
    idle(3);
    chk(busy == 1'b0 && busy_en == 1'b0 && ser_out_en == 1'b0, "R7 pins quiet",
        int'({busy, busy_en, ser_out_en}), 0);
    chk(trial_code == 11'd0, "R7 trial cleared", int'(trial_code), 0);
    send_addr(4'd13);
    chk({mux_diff, mux_chan} == 4'd2, "R7 clock ignored", int'({mux_diff, mux_chan}), 2);
    chk(busy_en == 1'b0, "R7 busy_en held off", int'(busy_en), 0);
    pwr_dn = 1'b0;
    sel_n = 1'b1;
    idle(20);
    run(4'd13, 1'b0, 10'd700);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule